// File: doc/BRIEF.md
# Row-Buffer Victim FIFO Profiler

This block watches a stream of DRAM row addresses aimed at a device that keeps one row open at a time. It models the open row, plus a short first-in first-out list of the rows most recently pushed out of it. Each access receives one of three outcomes:

- an open-row hit;
- a hit on a displaced row, tagged with the depth where that row was found;
- a miss in both the open row and the list.

The block keeps saturating statistics for each outcome, with one counter per list depth. It also times the gap between successive references to the row displaced most recently. The numbers show how much a small store of displaced rows would lift the row-buffer hit rate. They also show how deep such a store needs to be.

Accesses enter on a valid/ready stream. One classification leaves on a result stream for each accepted access. The result stream has a single output register. `acc_ready` is high whenever that register is empty or is being drained in the same cycle. A result that is not taken stays put and keeps the input stalled. The statistics and the interval are plain level outputs. A synchronous clear input zeroes them.

Top module: `rbv_profiler`

## Requirements
- R1: An accepted access whose row equals the valid open row reports class 0 (open hit) with depth 0. It adds one to `open_hits` and leaves the open row and the list unchanged.
- R2: An accepted access that matches neither the open row nor any valid list entry reports class 2 (miss) with depth 0 and adds one to `miss_cnt`. The row becomes the open row. The old open row, if valid, enters at depth 1, every entry moves one deeper, and the entry at depth DEPTH is lost. The first access after reset is a miss.
- R3: An accepted access found at list depth d (1 = most recently displaced, DEPTH = oldest) reports class 1 with depth d. It adds one to the counter at bits [(d-1)*CNT_W +: CNT_W] of `vict_hits`. The row becomes the open row and the old open row enters at depth 1. Entries above depth d move one deeper. Entries below d keep their places.
- R4: `acc_ready` equals `!res_valid || res_ready`. Results leave in acceptance order, one per accepted access. While `res_valid` is high and `res_ready` is low, the result holds its value.
- R5: Every statistic counter stops at 2^CNT_W-1 and never wraps.
- R6: `stat_clr` zeroes every counter, the interval timer and `gap_vld` at the next edge. An access accepted in the same cycle is not counted and raises no interval pulse. It still updates the row state and still delivers its result.
- R7: When an accepted access hits depth 1, `gap_vld` is high for the following cycle. In that cycle `gap` holds the number of clock edges since the previous depth-1 hit or the last clear, whichever came later, saturating at 2^CNT_W-1. In all other cycles `gap_vld` is low.
- R8: After reset there is no open row, the list is empty, all counters read 0, and `res_valid` and `gap_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_clr | input | 1 | Synchronous clear of statistics and timer |
| acc_valid | input | 1 | Access address present |
| acc_ready | output | 1 | Access accepted this cycle when valid |
| acc_row | input | ROW_W | Row address of the access |
| res_valid | output | 1 | Classification present |
| res_ready | input | 1 | Consumer takes the classification |
| res_class | output | 2 | 0 open hit, 1 list hit, 2 miss |
| res_depth | output | DEP_W | List depth of a hit, 0 otherwise |
| open_hits | output | CNT_W | Open-row hit count |
| vict_hits | output | DEPTH*CNT_W | Per-depth list hit counts, depth 1 in the low bits |
| miss_cnt | output | CNT_W | Miss count |
| gap | output | CNT_W | Last measured depth-1 re-reference interval |
| gap_vld | output | 1 | One-cycle pulse when `gap` is updated |

## Verification
A statistics clear can land in the same cycle as an accepted access. A depth-1 hit in that cycle carries the sharpest conflict. The bench drives `stat_clr` together with a valid access. It then expects every counter to read zero, no interval pulse, an unchanged result on the output stream, and an open row and list that moved as if no clear had happened. The next depth-1 hit must report a gap counted from that shared edge, which shows that the clear reset the timer while the row update went through.

// File: rtl/rbv_pkg.sv
package rbv_pkg;
  typedef enum logic [1:0] {
    RC_OPEN = 2'd0,
    RC_VICT = 2'd1,
    RC_MISS = 2'd2
  } rbv_class_e;
endpackage

// File: rtl/rbv_row_store.sv
module rbv_row_store #(
  parameter int ROW_W = 16,
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_hit,
  output logic             vic_hit,
  output logic [IDX_W-1:0] vic_idx
);
  logic [ROW_W-1:0] open_row;
  logic             open_vld;
  logic [ROW_W-1:0] ent [DEPTH];
  logic [DEPTH-1:0] ent_vld;
  logic [DEPTH-1:0] match;
  logic [IDX_W-1:0] lim;

  assign open_hit = open_vld && (open_row == row_in);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = ent_vld[g] && (ent[g] == row_in);
  end

  assign vic_hit = |match;

  always_comb begin
    vic_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (match[i]) vic_idx = vic_idx | IDX_W'(i);
  end

  // deepest position that takes part in the shift
  assign lim = vic_hit ? vic_idx : IDX_W'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_row <= '0;
      open_vld <= 1'b0;
      ent_vld  <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else if (upd && !open_hit) begin
      ent[0]     <= open_row;
      ent_vld[0] <= open_vld;
      for (int i = 1; i < DEPTH; i++) begin
        if (IDX_W'(i) <= lim) begin
          ent[i]     <= ent[i-1];
          ent_vld[i] <= ent_vld[i-1];
        end
      end
      open_row <= row_in;
      open_vld <= 1'b1;
    end
  end

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({match, open_hit}));
  a_r1_open_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    upd && open_hit |=> $stable(open_row) && $stable(ent_vld));
  a_r2_push: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !open_hit && !vic_hit && open_vld |=> ent[0] == $past(open_row) && open_row == $past(row_in));
  a_r3_promote: assert property (@(posedge clk) disable iff (!rst_n)
    upd && vic_hit |=> open_row == $past(row_in) && ent_vld[0]);
endmodule

// File: rtl/rbv_sat_ctr.sv
module rbv_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && cnt != TOP)  cnt <= cnt + W'(1);
  end

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == TOP && !clr |=> cnt == TOP);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/rbv_gap_timer.sv
module rbv_gap_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         evt,
  output logic [W-1:0] gap,
  output logic         gap_vld
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] tmr;
  logic [W-1:0] tmr_nx;

  assign tmr_nx = (tmr == TOP) ? TOP : tmr + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0; gap <= '0; gap_vld <= 1'b0;
    end else if (clr) begin
      tmr <= '0; gap <= '0; gap_vld <= 1'b0;
    end else if (evt) begin
      tmr <= '0; gap <= tmr_nx; gap_vld <= 1'b1;
    end else begin
      tmr <= tmr_nx; gap_vld <= 1'b0;
    end
  end

  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt && !clr |=> gap_vld && gap != '0);
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !evt || clr |=> !gap_vld);
endmodule

// File: rtl/rbv_profiler.sv
module rbv_profiler
  import rbv_pkg::*;
#(
  parameter int ROW_W = 16,
  parameter int DEPTH = 8,
  parameter int CNT_W = 16,
  parameter int DEP_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stat_clr,
  input  logic                   acc_valid,
  output logic                   acc_ready,
  input  logic [ROW_W-1:0]       acc_row,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [1:0]             res_class,
  output logic [DEP_W-1:0]       res_depth,
  output logic [CNT_W-1:0]       open_hits,
  output logic [DEPTH*CNT_W-1:0] vict_hits,
  output logic [CNT_W-1:0]       miss_cnt,
  output logic [CNT_W-1:0]       gap,
  output logic                   gap_vld
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             fire;
  logic             open_hit, vic_hit, vic_only;
  logic [IDX_W-1:0] vic_idx;
  rbv_class_e       cls;
  logic [DEP_W-1:0] dep;

  assign acc_ready = !res_valid || res_ready;
  assign fire      = acc_valid && acc_ready;
  assign vic_only  = vic_hit && !open_hit;

  rbv_row_store #(.ROW_W(ROW_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .upd(fire), .row_in(acc_row),
    .open_hit(open_hit), .vic_hit(vic_hit), .vic_idx(vic_idx)
  );

  always_comb begin
    if (open_hit)     cls = RC_OPEN;
    else if (vic_hit) cls = RC_VICT;
    else              cls = RC_MISS;
    dep = vic_only ? DEP_W'(vic_idx) + DEP_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_class <= '0;
      res_depth <= '0;
    end else if (fire) begin
      res_valid <= 1'b1;
      res_class <= cls;
      res_depth <= dep;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  rbv_sat_ctr #(.W(CNT_W)) u_open_ctr (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr),
    .inc(fire && open_hit), .cnt(open_hits)
  );

  rbv_sat_ctr #(.W(CNT_W)) u_miss_ctr (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr),
    .inc(fire && !open_hit && !vic_hit), .cnt(miss_cnt)
  );

  for (genvar d = 0; d < DEPTH; d++) begin : g_depth
    rbv_sat_ctr #(.W(CNT_W)) u_vic_ctr (
      .clk(clk), .rst_n(rst_n), .clr(stat_clr),
      .inc(fire && vic_only && vic_idx == IDX_W'(d)),
      .cnt(vict_hits[d*CNT_W +: CNT_W])
    );
  end

  rbv_gap_timer #(.W(CNT_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr),
    .evt(fire && vic_only && vic_idx == '0),
    .gap(gap), .gap_vld(gap_vld)
  );

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_class) && $stable(res_depth));
  a_r4_take: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready |=> res_valid);
  a_r3_depth_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_class == 2'd1 |-> res_depth != '0 && res_depth <= DEP_W'(DEPTH));
endmodule

// File: tb/rbv_profiler_tb.sv
module rbv_profiler_tb;
  localparam int CLK_P = 10;
  localparam int ROW_W = 16;
  localparam int DEPTH = 8;
  localparam int CNT_W = 4;
  localparam int DEP_W = 4;
  localparam int SAT   = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_clr = 1'b0;
  logic acc_valid = 1'b0;
  logic acc_ready;
  logic [ROW_W-1:0] acc_row = '0;
  logic res_valid;
  logic res_ready = 1'b1;
  logic [1:0] res_class;
  logic [DEP_W-1:0] res_depth;
  logic [CNT_W-1:0] open_hits, miss_cnt, gap;
  logic [DEPTH*CNT_W-1:0] vict_hits;
  logic gap_vld;

  always #(CLK_P/2) clk = ~clk;

  rbv_profiler #(.ROW_W(ROW_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .DEP_W(DEP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .stat_clr(stat_clr),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_row(acc_row),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_class(res_class), .res_depth(res_depth),
    .open_hits(open_hits), .vict_hits(vict_hits), .miss_cnt(miss_cnt),
    .gap(gap), .gap_vld(gap_vld)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  int q_cls[$];
  int q_dep[$];

  // independent reference state
  int m_open; bit m_ov;
  int m_f[DEPTH]; bit m_fv[DEPTH];
  int c_open, c_miss, c_vic[DEPTH], last_evt;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bump(int v);
    return (v >= SAT) ? SAT : v + 1;
  endfunction

  function automatic void model_step(int r, bit clr, output int cls, output int dep);
    int k;
    k = -1;
    for (int i = 0; i < DEPTH; i++) if (m_fv[i] && m_f[i] == r) k = i;
    if (m_ov && m_open == r) begin
      cls = 0; dep = 0;
      if (!clr) c_open = bump(c_open);
    end else begin
      int top;
      if (k >= 0) begin cls = 1; dep = k + 1; top = k; if (!clr) c_vic[k] = bump(c_vic[k]); end
      else begin cls = 2; dep = 0; top = DEPTH - 1; if (!clr) c_miss = bump(c_miss); end
      for (int i = top; i > 0; i--) begin m_f[i] = m_f[i-1]; m_fv[i] = m_fv[i-1]; end
      m_f[0] = m_open; m_fv[0] = m_ov;
      m_open = r; m_ov = 1;
    end
    if (clr) begin
      c_open = 0; c_miss = 0;
      for (int i = 0; i < DEPTH; i++) c_vic[i] = 0;
    end
  endfunction

  task automatic send(int r, bit clr_too);
    int cls, dep, exp_gap;
    bit want;
    @(negedge clk);
    acc_valid = 1; acc_row = ROW_W'(r); stat_clr = clr_too;
    while (!acc_ready) @(negedge clk);
    @(posedge clk); #1;
    acc_valid = 0; stat_clr = 0;
    model_step(r, clr_too, cls, dep);
    q_cls.push_back(cls); q_dep.push_back(dep);
    want = 0; exp_gap = 0;
    if (clr_too) last_evt = cyc;
    else if (cls == 1 && dep == 1) begin
      want = 1;
      exp_gap = (cyc - last_evt > SAT) ? SAT : cyc - last_evt;
      last_evt = cyc;
    end
    @(negedge clk);
    check("R7 gap_vld", int'(gap_vld), int'(want));
    if (want) check("R7 gap value", int'(gap), exp_gap);
  endtask

  task automatic check_counts(string tag);
    check({tag, " open_hits"}, int'(open_hits), c_open);
    check({tag, " miss_cnt"}, int'(miss_cnt), c_miss);
    for (int d = 0; d < DEPTH; d++)
      check({tag, " vict_hits"}, int'(vict_hits[d*CNT_W +: CNT_W]), c_vic[d]);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  // monitor: one result per accepted access, in order (R4, classes R1/R2/R3)
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (q_cls.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R4 unexpected result actual=%0d expected=none", res_class);
      end else begin
        int ec, ed;
        ec = q_cls.pop_front(); ed = q_dep.pop_front();
        check("R4 result class", int'(res_class), ec);
        check("R4 result depth", int'(res_depth), ed);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c0;
    m_ov = 0; c_open = 0; c_miss = 0; last_evt = 0;
    for (int i = 0; i < DEPTH; i++) begin m_fv[i] = 0; m_f[i] = 0; c_vic[i] = 0; end
    idle(3);
    @(negedge clk);
    check("R8 res_valid", int'(res_valid), 0);
    check("R8 gap_vld", int'(gap_vld), 0);
    check("R8 acc_ready", int'(acc_ready), 1);
    check_counts("R8");
    rst_n = 1;
    @(posedge clk); #1 last_evt = cyc;

    // fill and overflow the list with misses
    for (int r = 100; r < 110; r++) send(r, 0);
    check("R2 misses", int'(miss_cnt), 10);
    send(109, 0);
    check("R1 open hit", int'(open_hits), 1);
    send(100, 0);              // dropped past depth 8 -> miss
    check("R2 dropped row misses", int'(miss_cnt), 11);
    send(105, 0);              // depth 5
    check("R3 depth5 counter", int'(vict_hits[4*CNT_W +: CNT_W]), 1);
    // ping-pong on the most recently displaced row
    send(100, 0);
    idle(3);
    send(105, 0);
    idle(7);
    send(100, 0);
    send(102, 0);              // oldest position
    check("R3 depth8 counter", int'(vict_hits[7*CNT_W +: CNT_W]), 1);
    check_counts("R3");

    // back-pressure
    @(posedge clk); #1 res_ready = 0;
    send(300, 0);
    check("R4 stall ready", int'(acc_ready), 0);
    c0 = int'(res_class);
    repeat (3) @(negedge clk);
    check("R4 held valid", int'(res_valid), 1);
    check("R4 held class", int'(res_class), c0);
    @(posedge clk); #1 res_ready = 1;

    // saturation
    for (int i = 0; i < 20; i++) send(300, 0);
    check("R5 open saturates", int'(open_hits), SAT);
    check_counts("R5");

    // clear
    @(negedge clk); stat_clr = 1;
    @(posedge clk); #1 stat_clr = 0;
    last_evt = cyc; c_open = 0; c_miss = 0;
    for (int i = 0; i < DEPTH; i++) c_vic[i] = 0;
    @(negedge clk);
    check_counts("R6 clear");

    // clear coinciding with an access
    send(301, 1);
    check("R6 coincident not counted", int'(miss_cnt), 0);
    idle(2);
    send(300, 0);              // depth 1: gap from the shared edge
    check("R6 row state kept", int'(vict_hits[0 +: CNT_W]), 1);

    // interval saturation
    idle(25);
    send(301, 0);
    check_counts("R7");

    idle(4);
    check("R4 all results drained", q_cls.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule